// File: doc/BRIEF.md
# Cached FFT Cache Address Sequencer

This block walks the loop schedule of a radix-2 cached FFT that keeps a slice of the transform in a small register-file cache. For the default 128-point transform with a 32-entry cache, it steps through epochs, then through the groups inside each epoch, then through the passes inside each group, and finally through the butterflies inside each pass. For every butterfly it presents the two cache addresses of that butterfly's operands.

The two addresses share the same four counter bits. A single extra bit is placed among those bits: 0 for the first operand and 1 for the second. The position of the extra bit depends on the pass. Epoch 0 runs passes 0 to 4 and epoch 1 runs passes 5 and 6, so the passes are not split evenly between the two epochs. Alongside the addresses, the block marks the pass that fills the cache, the pass that writes it back, and the butterflies whose twiddle is trivial.

A controller pulses `start` to begin a transform schedule. It then raises `adv` once for each butterfly it consumes. The current butterfly stays on the outputs until `adv` is seen. After the last butterfly has been consumed, `done` pulses once.

Top module: `cfa_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `busy`, `done_o`, `load_o`, `dump_o` and `triv_o` are 0, and the epoch, group, pass and butterfly outputs are 0.
- R2: A `start` seen while idle makes `busy` 1 in the next cycle, with epoch 0, group 0, pass 0 and butterfly 0 on the outputs.
- R3: While busy with `adv` low, all index outputs hold their values and `busy` stays 1. While idle, `adv` has no effect: `busy` stays 0 and the indices stay 0.
- R4: Each `adv` seen while busy moves to the next butterfly. The butterfly index counts 0 to 15 within a pass. Epoch 0 visits groups 0 to 3 in turn, and each of those groups runs passes 0 to 4. Epoch 1 then visits groups 0 to 3 again, and each runs passes 5 and 6. The pass output carries the global pass number.
- R5: `addr_a` and `addr_b` are formed by inserting a bit into the 4-bit butterfly index at insertion position k. The index bits below k stay in place, and the index bits from k upward move up by one. The inserted bit is 0 in `addr_a` and 1 in `addr_b`.
- R6: The insertion position k equals the pass number in epoch 0, which gives 0 to 4. In epoch 1 it is the pass number minus 2, so pass 5 uses position 3 and pass 6 uses position 4.
- R7: While busy, `load_o` is 1 exactly during passes 0 and 5.
- R8: While busy, `dump_o` is 1 exactly during passes 4 and 6.
- R9: While busy, `triv_o` is 1 exactly during pass 0 of epoch 0. While idle, all three flags are 0.
- R10: A schedule takes exactly 448 accepted `adv` cycles. In the cycle after the last one, `done_o` is 1 for a single cycle, `busy` is 0 and all indices are back to 0.
- R11: `start` while busy is ignored: the schedule position is not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a schedule when idle |
| adv | input | 1 | Current butterfly consumed; step on |
| busy | output | 1 | Schedule in progress; outputs describe a butterfly |
| addr_a | output | 5 | Cache address of the first operand |
| addr_b | output | 5 | Cache address of the second operand |
| epoch_o | output | 1 | Current epoch |
| group_o | output | 2 | Current group within the epoch |
| pass_o | output | 3 | Global pass number, 0 to 6 |
| bfly_o | output | 4 | Butterfly index within the pass |
| load_o | output | 1 | Current pass fills the cache |
| dump_o | output | 1 | Current pass writes the cache back |
| triv_o | output | 1 | Current butterfly has a unit twiddle |
| done_o | output | 1 | One-cycle pulse after the final butterfly |

## Verification
The properties assume that `adv` and `start` are synchronous, single-bit, level-sampled controls. They may be asserted in any cycle, including `start` during a run and `adv` while idle. No ordering between them is required. The bench drives both from a seeded `$urandom` stream at the falling edge. This covers random stalls on `adv`, stray `start` pulses during a run, and `adv` pulses while idle. It adds directed runs with `adv` held high, plus a reset in the middle of a schedule.

// File: rtl/cfa_pkg.sv
// Shared definitions for the cached FFT address sequencer.
// Assumes nothing beyond a two-state run/idle controller.
package cfa_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } cfa_state_e;
endpackage

// File: rtl/cfa_loop_ctr.sv
// Loop-nest counter: epoch > group > pass > butterfly.
// Assumes LOG_N > CAW and LOG_N <= 2*CAW, so there are exactly two epochs.
// Epoch 0 owns passes 0..CAW-1 and epoch 1 owns passes CAW..LOG_N-1.
module cfa_loop_ctr
    import cfa_pkg::*;
#(
    parameter int LOG_N = 7,
    parameter int CAW   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     adv,
    output logic                     run,
    output logic                     epoch,
    output logic [LOG_N-CAW-1:0]     group,
    output logic [$clog2(LOG_N)-1:0] pass,
    output logic [CAW-2:0]           bfly,
    output logic                     done
);
    localparam int GW = LOG_N - CAW;
    localparam int PW = $clog2(LOG_N);
    localparam int BW = CAW - 1;

    cfa_state_e st;
    logic       bf_last, ps_last, gp_last;
    logic [PW-1:0] ps_first;

    // Detect the end of each loop level and the first pass of the current epoch.
    always_comb begin
        bf_last  = &bfly;
        gp_last  = &group;
        ps_last  = epoch ? (pass == PW'(LOG_N - 1)) : (pass == PW'(CAW - 1));
        ps_first = epoch ? PW'(CAW) : '0;
    end

    assign run = (st == ST_RUN);

    // Advance the loop nest one butterfly per accepted adv; pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            epoch <= 1'b0;
            group <= '0;
            pass  <= '0;
            bfly  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st    <= ST_RUN;
                        epoch <= 1'b0;
                        group <= '0;
                        pass  <= '0;
                        bfly  <= '0;
                    end
                end
                default: begin
                    if (adv) begin
                        if (!bf_last) begin
                            bfly <= bfly + BW'(1);
                        end else begin
                            bfly <= '0;
                            if (!ps_last) begin
                                pass <= pass + PW'(1);
                            end else if (!gp_last) begin
                                group <= group + GW'(1);
                                pass  <= ps_first;
                            end else if (!epoch) begin
                                epoch <= 1'b1;
                                group <= '0;
                                pass  <= PW'(CAW);
                            end else begin
                                st    <= ST_IDLE;
                                done  <= 1'b1;
                                epoch <= 1'b0;
                                group <= '0;
                                pass  <= '0;
                            end
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/cfa_addr_gen.sv
// Operand address former: inserts a 0/1 bit into the butterfly index at a
// pass-dependent position. Assumes the position never exceeds CAW-1.
module cfa_addr_gen #(
    parameter int LOG_N = 7,
    parameter int CAW   = 5
) (
    input  logic                     epoch,
    input  logic [$clog2(LOG_N)-1:0] pass,
    input  logic [CAW-2:0]           bfly,
    output logic [CAW-1:0]           addr_lo,
    output logic [CAW-1:0]           addr_hi
);
    localparam int PW = $clog2(LOG_N);

    logic [PW-1:0] pos;

    // Epoch 1 reuses the top insertion positions of epoch 0.
    always_comb pos = epoch ? (pass - PW'(LOG_N - CAW)) : pass;

    // One multiplexer per address bit: keep, insert, or shift up.
    for (genvar i = 0; i < CAW; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign addr_lo[i] = (pos == PW'(0)) ? 1'b0 : bfly[0];
            assign addr_hi[i] = (pos == PW'(0)) ? 1'b1 : bfly[0];
        end else if (i == CAW - 1) begin : g_msb
            assign addr_lo[i] = (pos == PW'(i)) ? 1'b0 : bfly[i-1];
            assign addr_hi[i] = (pos == PW'(i)) ? 1'b1 : bfly[i-1];
        end else begin : g_mid
            assign addr_lo[i] = (pos == PW'(i)) ? 1'b0 :
                                (pos >  PW'(i)) ? bfly[i] : bfly[i-1];
            assign addr_hi[i] = (pos == PW'(i)) ? 1'b1 :
                                (pos >  PW'(i)) ? bfly[i] : bfly[i-1];
        end
    end
endmodule

// File: rtl/cfa_flag_dec.sv
// Pass-role decoder: cache fill on each epoch's first pass, write-back on its
// last, unit twiddle on the first pass of epoch 0. Flags are low when idle.
module cfa_flag_dec #(
    parameter int LOG_N = 7,
    parameter int CAW   = 5
) (
    input  logic                     run,
    input  logic                     epoch,
    input  logic [$clog2(LOG_N)-1:0] pass,
    output logic                     load,
    output logic                     dump,
    output logic                     triv
);
    localparam int PW = $clog2(LOG_N);

    // Compare the pass number against the epoch's boundary passes.
    always_comb begin
        load = run && (pass == (epoch ? PW'(CAW) : PW'(0)));
        dump = run && (pass == (epoch ? PW'(LOG_N - 1) : PW'(CAW - 1)));
        triv = run && !epoch && (pass == PW'(0));
    end
endmodule

// File: rtl/cfa_seq.sv
// Top of the cached FFT cache address sequencer. Presents one butterfly's
// operand pair and pass role per cycle; steps on adv. Assumes LOG_N > CAW.
module cfa_seq #(
    parameter int LOG_N = 7,
    parameter int CAW   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     adv,
    output logic                     busy,
    output logic [CAW-1:0]           addr_a,
    output logic [CAW-1:0]           addr_b,
    output logic                     epoch_o,
    output logic [LOG_N-CAW-1:0]     group_o,
    output logic [$clog2(LOG_N)-1:0] pass_o,
    output logic [CAW-2:0]           bfly_o,
    output logic                     load_o,
    output logic                     dump_o,
    output logic                     triv_o,
    output logic                     done_o
);
    // Loop nest state.
    cfa_loop_ctr #(.LOG_N(LOG_N), .CAW(CAW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .start(start), .adv(adv),
        .run(busy), .epoch(epoch_o), .group(group_o), .pass(pass_o),
        .bfly(bfly_o), .done(done_o)
    );

    // Operand address pair.
    cfa_addr_gen #(.LOG_N(LOG_N), .CAW(CAW)) u_addr (
        .epoch(epoch_o), .pass(pass_o), .bfly(bfly_o),
        .addr_lo(addr_a), .addr_hi(addr_b)
    );

    // Pass-role flags.
    cfa_flag_dec #(.LOG_N(LOG_N), .CAW(CAW)) u_flag (
        .run(busy), .epoch(epoch_o), .pass(pass_o),
        .load(load_o), .dump(dump_o), .triv(triv_o)
    );
endmodule

// File: rtl/cfa_seq_chk.sv
// Temporal checks on the sequencer ports, bound into every cfa_seq instance.
module cfa_seq_chk #(
    parameter int LOG_N = 7,
    parameter int CAW   = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     adv,
    input logic                     busy,
    input logic [CAW-1:0]           addr_a,
    input logic [CAW-1:0]           addr_b,
    input logic                     epoch_o,
    input logic [LOG_N-CAW-1:0]     group_o,
    input logic [$clog2(LOG_N)-1:0] pass_o,
    input logic [CAW-2:0]           bfly_o,
    input logic                     load_o,
    input logic                     dump_o,
    input logic                     triv_o,
    input logic                     done_o
);
    localparam int BW = CAW - 1;

    // R4
    bfly_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && adv && !(&bfly_o) |=> busy && bfly_o == $past(bfly_o) + BW'(1));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !adv |=> busy && $stable({epoch_o, group_o, pass_o, bfly_o}));

    // R5
    pair_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $countones(addr_a ^ addr_b) == 1 && (addr_b & ~addr_a) != '0);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    triv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        triv_o |-> load_o && !epoch_o);

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !adv |=> busy && $stable(bfly_o));
endmodule

bind cfa_seq cfa_seq_chk #(.LOG_N(LOG_N), .CAW(CAW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(adv), .busy(busy),
    .addr_a(addr_a), .addr_b(addr_b), .epoch_o(epoch_o), .group_o(group_o),
    .pass_o(pass_o), .bfly_o(bfly_o), .load_o(load_o), .dump_o(dump_o),
    .triv_o(triv_o), .done_o(done_o)
);

// File: tb/cfa_seq_bench.sv
// Self-checking bench: seeded random stalls and stray starts, plus directed
// full-speed, idle-adv and mid-run reset cases.
module cfa_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       adv = 1'b0;
    logic       busy, epoch_o, load_o, dump_o, triv_o, done_o;
    logic [4:0] addr_a, addr_b;
    logic [1:0] group_o;
    logic [2:0] pass_o;
    logic [3:0] bfly_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    cfa_seq u_cfa_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .adv(adv), .busy(busy),
        .addr_a(addr_a), .addr_b(addr_b), .epoch_o(epoch_o), .group_o(group_o),
        .pass_o(pass_o), .bfly_o(bfly_o), .load_o(load_o), .dump_o(dump_o),
        .triv_o(triv_o), .done_o(done_o)
    );

    // Watchdog: a hung run is a failed check and still reports a summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: act=%0d exp<=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Insert bit v at position k into a 4-bit index.
    function automatic int ins_bit(input int b, input int k, input int v);
        int lo = b & ((1 << k) - 1);
        int hi = b >> k;
        return (hi << (k + 1)) | (v << k) | lo;
    endfunction

    task automatic chk_idle(input string req);
        chk({req, " busy"}, busy, 0);
        chk({req, " idx"}, {epoch_o, group_o, pass_o, bfly_o}, 0);
        chk({req, " flags"}, {load_o, dump_o, triv_o}, 0);
    endtask

    task automatic chk_pos(input int e, input int g, input int p, input int b);
        int k = (e == 0) ? p : p - 2;
        chk("R4 busy", busy, 1);
        chk("R4 epoch", epoch_o, e);
        chk("R4 group", group_o, g);
        chk("R4 pass", pass_o, p);
        chk("R4 bfly", bfly_o, b);
        chk("R5 R6 addr_a", addr_a, ins_bit(b, k, 0));
        chk("R5 R6 addr_b", addr_b, ins_bit(b, k, 1));
        chk("R7 load", load_o, (p == 0 || p == 5) ? 1 : 0);
        chk("R8 dump", dump_o, (p == 4 || p == 6) ? 1 : 0);
        chk("R9 triv", triv_o, (p == 0) ? 1 : 0);
    endtask

    // One full schedule; full_speed holds adv high, else random stalls.
    task automatic run_frame(input bit full_speed);
        int e = 0, g = 0, p = 0, b = 0, steps = 0;
        bit fin = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R2 busy after start", busy, 1);
        while (!fin) begin
            bit a;
            chk_pos(e, g, p, b);
            a = full_speed ? 1'b1 : (($urandom % 4) != 0);
            adv = a;
            start = (($urandom % 8) == 0);   // R11 stray start while busy
            @(negedge clk);
            adv = 1'b0;
            start = 1'b0;
            if (a) begin
                steps++;
                b++;
                if (b == 16) begin
                    b = 0;
                    p++;
                    if (p > ((e == 0) ? 4 : 6)) begin
                        g++;
                        p = (e == 0) ? 0 : 5;
                        if (g == 4) begin
                            g = 0;
                            if (e == 0) begin e = 1; p = 5; end
                            else fin = 1;
                        end
                    end
                end
            end
        end
        chk("R10 done pulse", done_o, 1);
        chk("R10 step count", steps, 448);
        chk_idle("R10 end");
        @(negedge clk);
        chk("R10 done one cycle", done_o, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        // R1 reset values while held
        chk_idle("R1 in reset");
        chk("R1 done", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after release");

        // R3 adv while idle has no effect
        adv = 1'b1;
        repeat (3) @(negedge clk);
        adv = 1'b0;
        chk_idle("R3 idle adv");

        run_frame(1'b1);
        run_frame(1'b0);
        run_frame(1'b0);

        // R1 reset in the middle of a schedule
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        adv = 1'b1;
        repeat (37) @(negedge clk);
        adv = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R1 mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 mid-run release");

        // R2 schedule restarts cleanly after reset
        run_frame(1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule